// File: doc/BRIEF.md
# Static Branch Predictor and Redirect Control

This block steers the fetch unit of a short in-order pipeline whenever a jump reaches decode. It sorts each jump by three properties: conditional or not, short (2-byte) or long (4-byte) encoding, and the sign of its displacement. Conditional jumps get a static direction guess from these properties. If the jump is unconditional, or is a conditional jump guessed taken, the block sends fetch to `pc + displacement` in the same cycle.

A conditional jump stays pending until the execute stage reports its real direction. At that point the block charges a fixed penalty that depends on the guess and the outcome. On a wrong guess it flushes the younger work and redirects fetch to the correct address. It rebuilds that address from its own saved copy of the jump's PC, displacement and length. Only one conditional jump can be pending. Any further jump that reaches decode in that time is held, while non-jump work keeps flowing. Condition evaluation and indirect target computation belong to other blocks.

Top module: `branch_redirect_ctrl`

## Requirements
- R1: A conditional jump with the short encoding (`dec_is_short`=1) is guessed taken whatever its displacement. In its decode cycle `redirect_valid`=1, `npc_sel`=1 (decode target) and `redirect_pc` = `dec_pc` + sign-extended `dec_disp`, modulo 2^PC_W.
- R2: A long conditional jump whose displacement has its sign bit set (backward) is guessed taken and redirected in decode exactly as in R1.
- R3: A long conditional jump whose displacement sign bit is clear (forward, zero included) is guessed not taken. Its decode cycle shows `redirect_valid`=0, `npc_sel`=0 (sequential) and `redirect_pc`=0.
- R4: An unconditional jump is redirected in its decode cycle to `dec_pc` + sign-extended `dec_disp`, with `npc_sel`=1 and `pen_cnt`=1. It leaves nothing pending.
- R5: In the cycle a pending conditional jump resolves (`ex_valid`=1), `pen_cnt` reports the penalty for that guess and outcome. Guessed taken and taken gives 1. Guessed taken and not taken gives 2. Guessed not taken and taken gives 2. Guessed not taken and not taken gives 0.
- R6: When the guess was wrong, the resolve cycle shows `flush`=1, `redirect_valid`=1 and `npc_sel`=2 (execute fix-up). If taken, `redirect_pc` is the saved PC plus displacement. If not taken, it is the saved PC plus 2 (short) or 4 (long). When the guess was right, `flush`=0 and no redirect is made.
- R7: From the cycle after a conditional jump is accepted up to and including its resolve cycle, a jump in decode raises `dec_hold`=1 and gets no decode redirect. A non-jump in that window has `dec_hold`=0.
- R8: `ex_valid` has no effect when nothing is pending. All outputs keep the values the decode inputs alone call for.
- R9: During and right after reset nothing is pending. All outputs are 0 when decode carries no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_is_jump | input | 1 | That instruction is a direct jump |
| dec_is_cond | input | 1 | The jump is conditional |
| dec_is_short | input | 1 | 2-byte encoding (else 4-byte) |
| dec_disp | input | DISP_W | Signed byte displacement |
| dec_pc | input | PC_W | PC of the decode instruction |
| ex_valid | input | 1 | Execute reports the pending jump's direction |
| ex_taken | input | 1 | Actual direction from execute |
| dec_hold | output | 1 | Decode must hold its jump this cycle |
| npc_sel | output | 2 | 0 sequential, 1 decode target, 2 execute fix-up |
| redirect_valid | output | 1 | Fetch must go to `redirect_pc` |
| redirect_pc | output | PC_W | Redirect address |
| flush | output | 1 | Kill younger instructions |
| pen_cnt | output | 2 | Bubble count charged this cycle |

## Verification
The assertions check several rules on every cycle. Held jumps never get a decode redirect. Every flush comes with a fix-up redirect and a penalty of 2. An unconditional jump always gets a penalty of 1. A forward long conditional never redirects. `ex_valid` with nothing pending never flushes. The bench sweeps every displacement, both encodings and both outcomes, with PCs chosen to wrap the address space. Only these scenarios can show that the redirect addresses, the rebuilt fall-through addresses and the full penalty table are correct, and that the hold window ends at the right cycle.

// File: rtl/brp_pkg.sv
// Shared definitions for the branch redirect control.
// Assumes a penalty never exceeds 2 bubbles, so two bits suffice.
package brp_pkg;

    // Next-PC source handed to the fetch unit.
    typedef enum logic [1:0] {
        NPC_SEQ = 2'd0,
        NPC_DEC = 2'd1,
        NPC_FIX = 2'd2
    } npc_sel_e;

    localparam int PEN_W = 2;

    // Bubble cost of a conditional jump given its static guess and its outcome.
    function automatic logic [PEN_W-1:0] jump_penalty(input logic guess, input logic actual);
        if (guess) return actual ? 2'd1 : 2'd2;
        else       return actual ? 2'd2 : 2'd0;
    endfunction

endpackage

// File: rtl/brp_classify.sv
// Sorts a decode jump into unconditional / conditional and makes the static guess.
// Assumes the displacement is two's complement, so its top bit marks backward.
module brp_classify #(
    parameter int DISP_W = 8
) (
    input  logic              is_jump,
    input  logic              is_cond,
    input  logic              is_short,
    input  logic [DISP_W-1:0] disp,
    output logic              uncond,
    output logic              cond,
    output logic              guess_taken
);
    localparam int SIGN_BIT = DISP_W - 1;

    // Kind of jump and the direction guess for conditional ones.
    always_comb begin
        uncond      = is_jump & ~is_cond;
        cond        = is_jump & is_cond;
        guess_taken = is_short | disp[SIGN_BIT];
    end
endmodule

// File: rtl/brp_target.sv
// Forms either the jump target (pc + signed disp) or the fall-through (pc + length).
// Assumes addresses wrap modulo 2^PC_W.
module brp_target #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              is_short,
    input  logic              pick_target,
    output logic [PC_W-1:0]   addr
);
    localparam logic [PC_W-1:0] STEP_SHORT = PC_W'(2);
    localparam logic [PC_W-1:0] STEP_LONG  = PC_W'(4);

    logic [PC_W-1:0] disp_ext;

    generate
        if (DISP_W < PC_W) begin : g_sext
            // Sign-extend the displacement to the address width.
            always_comb disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            // Displacement at least as wide as the address: keep the low bits.
            always_comb disp_ext = disp[PC_W-1:0];
        end
    endgenerate

    // Choose between target and fall-through address.
    always_comb begin
        if (pick_target) addr = pc + disp_ext;
        else             addr = pc + (is_short ? STEP_SHORT : STEP_LONG);
    end
endmodule

// File: rtl/brp_resolve.sv
// Holds the one pending conditional jump and settles it when execute reports.
// Assumes execute reports at most once per accepted jump and never in the accept cycle.
module brp_resolve #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        accept,
    input  logic [PC_W-1:0]             pc_in,
    input  logic [DISP_W-1:0]           disp_in,
    input  logic                        short_in,
    input  logic                        guess_in,
    input  logic                        ex_valid,
    input  logic                        ex_taken,
    output logic                        pending,
    output logic                        settle,
    output logic                        wrong,
    output logic [PC_W-1:0]             fix_pc,
    output logic [brp_pkg::PEN_W-1:0]   pen
);
    logic              pend_q;
    logic [PC_W-1:0]   pc_q;
    logic [DISP_W-1:0] disp_q;
    logic              short_q;
    logic              guess_q;

    // Pending flag: set on accept, cleared in the settle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (settle)     pend_q <= 1'b0;
        else if (accept)     pend_q <= 1'b1;
    end

    // Saved copy of the jump used to rebuild the corrected address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            disp_q  <= '0;
            short_q <= 1'b0;
            guess_q <= 1'b0;
        end else if (accept) begin
            pc_q    <= pc_in;
            disp_q  <= disp_in;
            short_q <= short_in;
            guess_q <= guess_in;
        end
    end

    brp_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_fix (
        .pc          (pc_q),
        .disp        (disp_q),
        .is_short    (short_q),
        .pick_target (ex_taken),
        .addr        (fix_pc)
    );

    // Outcome versus guess and the resulting penalty.
    always_comb begin
        pending = pend_q;
        settle  = pend_q & ex_valid;
        wrong   = settle & (guess_q != ex_taken);
        pen     = settle ? brp_pkg::jump_penalty(guess_q, ex_taken) : '0;
    end
endmodule

// File: rtl/branch_redirect_ctrl.sv
// Top of the static branch predictor and redirect control.
// Assumes a single decode slot, one pending conditional jump at a time, and
// that execute resolution outranks any decode redirect in the same cycle.
module branch_redirect_ctrl #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dec_valid,
    input  logic                        dec_is_jump,
    input  logic                        dec_is_cond,
    input  logic                        dec_is_short,
    input  logic [DISP_W-1:0]           dec_disp,
    input  logic [PC_W-1:0]             dec_pc,
    input  logic                        ex_valid,
    input  logic                        ex_taken,
    output logic                        dec_hold,
    output logic [1:0]                  npc_sel,
    output logic                        redirect_valid,
    output logic [PC_W-1:0]             redirect_pc,
    output logic                        flush,
    output logic [brp_pkg::PEN_W-1:0]   pen_cnt
);
    import brp_pkg::*;

    logic            is_uncond, is_cond, guess;
    logic            pending, settle, wrong, go, accept;
    logic [PC_W-1:0] dec_tgt, fix_pc;
    logic [PEN_W-1:0] res_pen;

    brp_classify #(.DISP_W(DISP_W)) u_cls (
        .is_jump     (dec_valid & dec_is_jump),
        .is_cond     (dec_is_cond),
        .is_short    (dec_is_short),
        .disp        (dec_disp),
        .uncond      (is_uncond),
        .cond        (is_cond),
        .guess_taken (guess)
    );

    brp_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_dtgt (
        .pc          (dec_pc),
        .disp        (dec_disp),
        .is_short    (dec_is_short),
        .pick_target (1'b1),
        .addr        (dec_tgt)
    );

    brp_resolve #(.PC_W(PC_W), .DISP_W(DISP_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .pc_in    (dec_pc),
        .disp_in  (dec_disp),
        .short_in (dec_is_short),
        .guess_in (guess),
        .ex_valid (ex_valid),
        .ex_taken (ex_taken),
        .pending  (pending),
        .settle   (settle),
        .wrong    (wrong),
        .fix_pc   (fix_pc),
        .pen      (res_pen)
    );

    // Decode gating: jumps wait while a conditional is outstanding.
    always_comb begin
        dec_hold = pending & (is_uncond | is_cond);
        go       = ~pending;
        accept   = go & is_cond;
    end

    // Output steering: execute fix-up first, then decode redirect.
    always_comb begin
        npc_sel        = NPC_SEQ;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        flush          = 1'b0;
        pen_cnt        = '0;
        if (settle) begin
            pen_cnt = res_pen;
            if (wrong) begin
                flush          = 1'b1;
                redirect_valid = 1'b1;
                npc_sel        = NPC_FIX;
                redirect_pc    = fix_pc;
            end
        end else if (go && (is_uncond || (is_cond && guess))) begin
            redirect_valid = 1'b1;
            npc_sel        = NPC_DEC;
            redirect_pc    = dec_tgt;
            pen_cnt        = is_uncond ? PEN_W'(1) : '0;
        end
    end
endmodule

// File: rtl/branch_redirect_ctrl_chk.sv
// Checker bound to the top: tracks its own pending flag from the ports and
// checks the cycle-by-cycle redirect rules.
module branch_redirect_ctrl_chk #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic              dec_is_jump,
    input logic              dec_is_cond,
    input logic              dec_is_short,
    input logic [DISP_W-1:0] dec_disp,
    input logic              ex_valid,
    input logic              dec_hold,
    input logic [1:0]        npc_sel,
    input logic              redirect_valid,
    input logic              flush,
    input logic [1:0]        pen_cnt
);
    logic chk_pend;

    // Own model of the outstanding conditional jump.
    always_ff @(posedge clk) begin
        if (!rst_n)                   chk_pend <= 1'b0;
        else if (chk_pend && ex_valid) chk_pend <= 1'b0;
        else if (!chk_pend && dec_valid && dec_is_jump && dec_is_cond) chk_pend <= 1'b1;
    end

    // R7
    hold_no_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hold |-> npc_sel != 2'd1);
    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_pend |-> !dec_hold);
    // R6
    flush_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (redirect_valid && npc_sel == 2'd2 && pen_cnt == 2'd2));
    // R4
    uncond_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_pend && dec_valid && dec_is_jump && !dec_is_cond) |->
            (redirect_valid && npc_sel == 2'd1 && pen_cnt == 2'd1));
    // R3
    fwd_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_pend && dec_valid && dec_is_jump && dec_is_cond && !dec_is_short
         && !dec_disp[DISP_W-1]) |-> !redirect_valid);
    // R8
    stray_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_pend && ex_valid) |-> (!flush && npc_sel != 2'd2));
    // R5
    pen_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pen_cnt != 2'd3);
endmodule

bind branch_redirect_ctrl branch_redirect_ctrl_chk #(.PC_W(PC_W), .DISP_W(DISP_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dec_valid      (dec_valid),
    .dec_is_jump    (dec_is_jump),
    .dec_is_cond    (dec_is_cond),
    .dec_is_short   (dec_is_short),
    .dec_disp       (dec_disp),
    .ex_valid       (ex_valid),
    .dec_hold       (dec_hold),
    .npc_sel        (npc_sel),
    .redirect_valid (redirect_valid),
    .flush          (flush),
    .pen_cnt        (pen_cnt)
);

// File: tb/branch_redirect_ctrl_test.sv
// Sweeps every displacement, both encodings and both outcomes.
module branch_redirect_ctrl_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PC_W = 16;
    localparam int DISP_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0, dec_is_jump = 1'b0, dec_is_cond = 1'b0, dec_is_short = 1'b0;
    logic [DISP_W-1:0] dec_disp = '0;
    logic [PC_W-1:0]   dec_pc = '0;
    logic ex_valid = 1'b0, ex_taken = 1'b0;
    logic dec_hold, redirect_valid, flush;
    logic [1:0] npc_sel, pen_cnt;
    logic [PC_W-1:0] redirect_pc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    branch_redirect_ctrl #(.PC_W(PC_W), .DISP_W(DISP_W)) uut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_jump(dec_is_jump),
        .dec_is_cond(dec_is_cond), .dec_is_short(dec_is_short), .dec_disp(dec_disp),
        .dec_pc(dec_pc), .ex_valid(ex_valid), .ex_taken(ex_taken), .dec_hold(dec_hold),
        .npc_sel(npc_sel), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .flush(flush), .pen_cnt(pen_cnt)
    );

    function automatic logic [PC_W-1:0] tgt(input logic [PC_W-1:0] pc, input logic [DISP_W-1:0] d);
        return pc + {{(PC_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    // Compare all outputs at once: {hold, sel, rv, rpc, flush, pen}.
    task automatic check(input string req, input logic eh, input logic [1:0] es, input logic erv,
                         input logic [PC_W-1:0] epc, input logic ef, input logic [1:0] ep);
        logic [22:0] act, exp;
        act = {dec_hold, npc_sel, redirect_valid, redirect_pc, flush, pen_cnt};
        exp = {eh, es, erv, epc, ef, ep};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic j, input logic c, input logic s,
                         input logic [DISP_W-1:0] d, input logic [PC_W-1:0] pc,
                         input logic xv, input logic xt);
        @(negedge clk);
        dec_valid = v; dec_is_jump = j; dec_is_cond = c; dec_is_short = s;
        dec_disp = d; dec_pc = pc; ex_valid = xv; ex_taken = xt;
        #1;
    endtask

    initial begin
        logic [PC_W-1:0] pc;
        pc = 16'hFF80;
        // R9: idle outputs during reset, even with a stray ex_valid
        drive(0, 0, 0, 0, '0, '0, 1, 1);
        check("R9", 0, 0, 0, '0, 0, 0);
        drive(0, 0, 0, 0, '0, '0, 0, 0);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, '0, '0, 0, 0);
        check("R9", 0, 0, 0, '0, 0, 0);

        for (int s = 0; s < 2; s++) begin
            for (int d = 0; d < 256; d++) begin
                for (int t = 0; t < 2; t++) begin
                    logic g;
                    logic [1:0] ep;
                    logic [PC_W-1:0] fx;
                    g = (s == 1) || d[7];
                    pc = pc + 16'd37;
                    // Decode cycle: R1 short, R2 backward long, R3 forward long
                    drive(1, 1, 1, s[0], d[7:0], pc, 0, 0);
                    if (g) check(s == 1 ? "R1" : "R2", 0, 2'd1, 1, tgt(pc, d[7:0]), 0, 0);
                    else   check("R3", 0, 0, 0, '0, 0, 0);
                    // R7: held jump, or a passing non-jump
                    if (d[0]) begin
                        drive(1, 1, 0, 0, 8'h10, pc + 16'd100, 0, 0);
                        check("R7", 1, 0, 0, '0, 0, 0);
                    end else begin
                        drive(1, 0, 0, 0, 8'h10, pc + 16'd100, 0, 0);
                        check("R7", 0, 0, 0, '0, 0, 0);
                    end
                    // Resolve cycle with a jump still waiting in decode
                    drive(1, 1, 0, 1, 8'h20, pc + 16'd200, 1, t[0]);
                    ep = g ? (t == 1 ? 2'd1 : 2'd2) : (t == 1 ? 2'd2 : 2'd0);
                    fx = (t == 1) ? tgt(pc, d[7:0]) : pc + (s == 1 ? 16'd2 : 16'd4);
                    if (g != t[0]) check("R6", 1, 2'd2, 1, fx, 1, ep);
                    else           check("R5", 1, 0, 0, '0, 0, ep);
                end
            end
            // R4: unconditional sweep, then R8 stray resolution
            for (int d = 0; d < 256; d += 3) begin
                pc = pc - 16'd91;
                drive(1, 1, 0, s[0], d[7:0], pc, 0, 0);
                check("R4", 0, 2'd1, 1, tgt(pc, d[7:0]), 0, 2'd1);
                drive(0, 0, 0, 0, '0, pc, 1, d[1]);
                check("R8", 0, 0, 0, '0, 0, 0);
            end
        end
        // R8: stray ex_valid together with a short conditional jump in decode
        drive(1, 1, 1, 1, 8'hFE, 16'h0001, 1, 0);
        check("R8", 0, 2'd1, 1, 16'hFFFF, 0, 0);
        drive(0, 0, 0, 0, '0, '0, 1, 1);
        check("R5", 0, 0, 0, '0, 0, 2'd1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule